// File: doc/BRIEF.md
# Variant-Configurable Command Decoder

This block accepts an 8-bit command token, qualified by a valid strobe, together with an argument word. It either applies the command to a small bank of parameter outputs or refuses it. Every accepted command returns exactly one response strobe, one clock later. An ok strobe means the command was carried out. A not-ok strobe means the code is undefined or is not available in this build.

A compile-time parameter picks one of three variants. The full variant accepts all six commands. Variant A and variant B each leave out a different pair. Before the decode step, a prescreen stage checks each token against a constant 256-entry support map. The map is derived from the variant parameter. A token that is not in the map is rewritten to the reserved code 8'hFF. As a result, a command that a variant leaves out takes the same decode path as an undefined code, and synthesis can remove the logic behind it.

The command set has four bit-setting commands, one trigger pulse and one set-point load. The set-point value feeds a DAC.

Top module: `cmd_decoder`

## Requirements
- R1: While rst_n is low, and on the first cycle after its release, every parameter output is zero and trig_o, resp_ok_o and resp_nok_o are low.
- R2: A command is taken only on a rising clock edge where cmd_valid is high. Exactly one of resp_ok_o or resp_nok_o is high in the following cycle, for that cycle only. When cmd_valid is low, no output changes and no response appears.
- R3: The set commands copy cmd_arg[0] into their target and give ok. The other argument bits have no effect. Token 8'h10 drives en_o, 8'h11 drives mute_o, 8'h12 drives boost_o and 8'h40 drives aux_o.
- R4: Any token outside {8'h10, 8'h11, 8'h12, 8'h20, 8'h30, 8'h40} gives not-ok and leaves every parameter output unchanged. This includes the reserved code 8'hFF.
- R5: resp_ok_o and resp_nok_o are never high in the same cycle.
- R6: Token 8'h20 raises trig_o for exactly the response cycle, together with ok, and stores nothing.
- R7: Token 8'h30 loads the whole argument word into setpt_o and gives ok. setpt_o changes at no other time.
- R8: With VARIANT = 0 (full), all six commands are accepted.
- R9: With VARIANT = 1 (A), tokens 8'h12 and 8'h40 behave exactly like undefined codes, and boost_o and aux_o stay zero permanently.
- R10: With VARIANT = 2 (B), tokens 8'h11 and 8'h30 behave exactly like undefined codes, and mute_o and setpt_o stay zero permanently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_valid | input | 1 | Qualifies token and argument |
| cmd_token | input | 8 | Command code |
| cmd_arg | input | ARG_W | Argument word |
| en_o | output | 1 | Enable parameter bit |
| mute_o | output | 1 | Mute parameter bit |
| boost_o | output | 1 | Boost parameter bit |
| aux_o | output | 1 | Auxiliary parameter bit |
| setpt_o | output | ARG_W | Set-point word for the DAC |
| trig_o | output | 1 | One-cycle capture trigger |
| resp_ok_o | output | 1 | Command handled |
| resp_nok_o | output | 1 | Command not implemented |

## Verification
The bench drives identical traffic into all three variants in parallel. It uses a per-variant reference table, so a prescreen map that lets a disabled command through shows up as a wrong ok strobe and a changed output in one variant only. Arguments with bit 0 clear and every other bit set are used to catch a set command that takes the wrong argument bit. Undefined codes are sent, including the reserved 8'hFF, to catch a decoder that alters outputs on a rejection. Back-to-back commands and a valid-low token are sent as well: a response that arrives a cycle late, a trigger that is stretched, or a command taken while valid is low would each disturb the strobe sequence that the scoreboard expects.

// File: rtl/cmd_pkg.sv
package cmd_pkg;
  localparam int TOK_W = 8;
  localparam int TOK_N = 1 << TOK_W;

  localparam int VARIANT_FULL = 0;
  localparam int VARIANT_A    = 1;
  localparam int VARIANT_B    = 2;

  localparam logic [TOK_W-1:0] TOK_EN      = 8'h10;
  localparam logic [TOK_W-1:0] TOK_MUTE    = 8'h11;
  localparam logic [TOK_W-1:0] TOK_BOOST   = 8'h12;
  localparam logic [TOK_W-1:0] TOK_FIRE    = 8'h20;
  localparam logic [TOK_W-1:0] TOK_SETPT   = 8'h30;
  localparam logic [TOK_W-1:0] TOK_AUX     = 8'h40;
  localparam logic [TOK_W-1:0] TOK_INVALID = 8'hFF;

  // one command's availability in a given variant
  function automatic logic cmd_enabled(int variant, logic [TOK_W-1:0] tok);
    logic hit;
    hit = 1'b0;
    case (tok)
      TOK_EN, TOK_FIRE:  hit = 1'b1;
      TOK_MUTE, TOK_SETPT: hit = (variant != VARIANT_B);
      TOK_BOOST, TOK_AUX:  hit = (variant != VARIANT_A);
      default:           hit = 1'b0;
    endcase
    return hit;
  endfunction

  // full support map, evaluated at elaboration
  function automatic logic [TOK_N-1:0] build_map(int variant);
    logic [TOK_N-1:0] m;
    for (int i = 0; i < TOK_N; i++) begin
      m[i] = cmd_enabled(variant, TOK_W'(i));
    end
    return m;
  endfunction
endpackage

// File: rtl/cmd_prescreen.sv
module cmd_prescreen
  import cmd_pkg::*;
#(
  parameter int VARIANT = VARIANT_FULL
) (
  input  logic [TOK_W-1:0] tok_i,
  output logic [TOK_W-1:0] tok_o
);
  localparam logic [TOK_N-1:0] SUPPORT_MAP = build_map(VARIANT);

  always_comb begin
    tok_o = SUPPORT_MAP[tok_i] ? tok_i : TOK_INVALID;
  end
endmodule

// File: rtl/cmd_exec.sv
module cmd_exec
  import cmd_pkg::*;
#(
  parameter int ARG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [TOK_W-1:0] tok_i,
  input  logic [ARG_W-1:0] arg_i,
  output logic             en_o,
  output logic             mute_o,
  output logic             boost_o,
  output logic             aux_o,
  output logic [ARG_W-1:0] setpt_o,
  output logic             trig_o,
  output logic             ok_o,
  output logic             nok_o
);
  logic             en_n, mute_n, boost_n, aux_n;
  logic [ARG_W-1:0] setpt_n;
  logic             trig_n, ok_n, nok_n;

  always_comb begin
    en_n    = en_o;
    mute_n  = mute_o;
    boost_n = boost_o;
    aux_n   = aux_o;
    setpt_n = setpt_o;
    trig_n  = 1'b0;
    ok_n    = 1'b0;
    nok_n   = 1'b0;
    if (valid_i) begin
      case (tok_i)
        TOK_EN:    begin en_n    = arg_i[0]; ok_n = 1'b1; end
        TOK_MUTE:  begin mute_n  = arg_i[0]; ok_n = 1'b1; end
        TOK_BOOST: begin boost_n = arg_i[0]; ok_n = 1'b1; end
        TOK_AUX:   begin aux_n   = arg_i[0]; ok_n = 1'b1; end
        TOK_SETPT: begin setpt_n = arg_i;    ok_n = 1'b1; end
        TOK_FIRE:  begin trig_n  = 1'b1;     ok_n = 1'b1; end
        default:   nok_n = 1'b1;
      endcase
    end
  end

  // parameter bank: updated only under the command enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o    <= 1'b0;
      mute_o  <= 1'b0;
      boost_o <= 1'b0;
      aux_o   <= 1'b0;
      setpt_o <= '0;
    end else if (valid_i) begin
      en_o    <= en_n;
      mute_o  <= mute_n;
      boost_o <= boost_n;
      aux_o   <= aux_n;
      setpt_o <= setpt_n;
    end
  end

  // strobes: refreshed every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_o <= 1'b0;
      ok_o   <= 1'b0;
      nok_o  <= 1'b0;
    end else begin
      trig_o <= trig_n;
      ok_o   <= ok_n;
      nok_o  <= nok_n;
    end
  end
endmodule

// File: rtl/cmd_decoder.sv
module cmd_decoder
  import cmd_pkg::*;
#(
  parameter int VARIANT = VARIANT_FULL,
  parameter int ARG_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [TOK_W-1:0] cmd_token,
  input  logic [ARG_W-1:0] cmd_arg,
  output logic             en_o,
  output logic             mute_o,
  output logic             boost_o,
  output logic             aux_o,
  output logic [ARG_W-1:0] setpt_o,
  output logic             trig_o,
  output logic             resp_ok_o,
  output logic             resp_nok_o
);
  logic [TOK_W-1:0] screened_tok;

  cmd_prescreen #(.VARIANT(VARIANT)) u_screen (
    .tok_i (cmd_token),
    .tok_o (screened_tok)
  );

  cmd_exec #(.ARG_W(ARG_W)) u_exec (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (cmd_valid),
    .tok_i   (screened_tok),
    .arg_i   (cmd_arg),
    .en_o    (en_o),
    .mute_o  (mute_o),
    .boost_o (boost_o),
    .aux_o   (aux_o),
    .setpt_o (setpt_o),
    .trig_o  (trig_o),
    .ok_o    (resp_ok_o),
    .nok_o   (resp_nok_o)
  );
endmodule

// File: rtl/cmd_decoder_chk.sv
module cmd_decoder_chk
  import cmd_pkg::*;
#(
  parameter int VARIANT = VARIANT_FULL,
  parameter int ARG_W   = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [TOK_W-1:0] cmd_token,
  input logic [ARG_W-1:0] cmd_arg,
  input logic             en_o,
  input logic             mute_o,
  input logic             boost_o,
  input logic             aux_o,
  input logic [ARG_W-1:0] setpt_o,
  input logic             trig_o,
  input logic             resp_ok_o,
  input logic             resp_nok_o
);
  AST_RESP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_ok_o && resp_nok_o)); // R5

  AST_RESP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_ok_o || resp_nok_o) |-> $past(cmd_valid)); // R2

  AST_RESP_EVERY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (resp_ok_o || resp_nok_o)); // R2

  AST_TRIG_WITH_OK: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> resp_ok_o); // R6

  AST_NOK_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_nok_o |-> ($stable(en_o) && $stable(mute_o) && $stable(boost_o)
                    && $stable(aux_o) && $stable(setpt_o))); // R4

  AST_SETPT_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(setpt_o) |-> ($past(cmd_valid) && $past(cmd_token) == TOK_SETPT)); // R7

  generate
    if (VARIANT == VARIANT_A) begin : g_chk_a
      AST_A_PRUNED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !boost_o && !aux_o); // R9
    end else if (VARIANT == VARIANT_B) begin : g_chk_b
      AST_B_PRUNED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !mute_o && setpt_o == '0); // R10
    end
  endgenerate
endmodule

bind cmd_decoder cmd_decoder_chk #(.VARIANT(VARIANT), .ARG_W(ARG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_token  (cmd_token),
  .cmd_arg    (cmd_arg),
  .en_o       (en_o),
  .mute_o     (mute_o),
  .boost_o    (boost_o),
  .aux_o      (aux_o),
  .setpt_o    (setpt_o),
  .trig_o     (trig_o),
  .resp_ok_o  (resp_ok_o),
  .resp_nok_o (resp_nok_o)
);

// File: tb/cmd_decoder_test.sv
module cmd_decoder_test;
  localparam int AW = 16;

  logic          clk;
  logic          rst_n;
  logic          cmd_valid;
  logic [7:0]    cmd_token;
  logic [AW-1:0] cmd_arg;

  logic [2:0]    a_en, a_mute, a_boost, a_aux, a_trig, a_ok, a_nok;
  logic [AW-1:0] a_sp [3];

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  cmd_decoder #(.VARIANT(0), .ARG_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_token(cmd_token),
    .cmd_arg(cmd_arg), .en_o(a_en[0]), .mute_o(a_mute[0]), .boost_o(a_boost[0]),
    .aux_o(a_aux[0]), .setpt_o(a_sp[0]), .trig_o(a_trig[0]),
    .resp_ok_o(a_ok[0]), .resp_nok_o(a_nok[0]));

  cmd_decoder #(.VARIANT(1), .ARG_W(AW)) uut_a (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_token(cmd_token),
    .cmd_arg(cmd_arg), .en_o(a_en[1]), .mute_o(a_mute[1]), .boost_o(a_boost[1]),
    .aux_o(a_aux[1]), .setpt_o(a_sp[1]), .trig_o(a_trig[1]),
    .resp_ok_o(a_ok[1]), .resp_nok_o(a_nok[1]));

  cmd_decoder #(.VARIANT(2), .ARG_W(AW)) uut_b (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_token(cmd_token),
    .cmd_arg(cmd_arg), .en_o(a_en[2]), .mute_o(a_mute[2]), .boost_o(a_boost[2]),
    .aux_o(a_aux[2]), .setpt_o(a_sp[2]), .trig_o(a_trig[2]),
    .resp_ok_o(a_ok[2]), .resp_nok_o(a_nok[2]));

  typedef struct {
    logic [2:0]    en, mute, boost, aux, trig, ok, nok;
    logic [AW-1:0] sp [3];
    string         tag;
  } exp_t;

  exp_t exp_q[$];

  // reference model state
  logic [2:0]    m_en, m_mute, m_boost, m_aux;
  logic [AW-1:0] m_sp [3];

  // independent support table: 0 full, 1 A, 2 B
  function automatic bit ref_sup(int v, logic [7:0] t);
    case (t)
      8'h10, 8'h20: return 1'b1;
      8'h11, 8'h30: return v != 2;
      8'h12, 8'h40: return v != 1;
      default:      return 1'b0;
    endcase
  endfunction

  task automatic check(string tag, string what, logic [AW-1:0] act, logic [AW-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic send(logic v, logic [7:0] tok, logic [AW-1:0] arg, string tag);
    exp_t e;
    @(negedge clk);
    cmd_valid = v;
    cmd_token = tok;
    cmd_arg   = arg;
    e.trig = '0; e.ok = '0; e.nok = '0;
    for (int i = 0; i < 3; i++) begin
      if (v) begin
        if (ref_sup(i, tok)) begin
          e.ok[i] = 1'b1;
          case (tok)
            8'h10: m_en[i]    = arg[0];
            8'h11: m_mute[i]  = arg[0];
            8'h12: m_boost[i] = arg[0];
            8'h40: m_aux[i]   = arg[0];
            8'h30: m_sp[i]    = arg;
            8'h20: e.trig[i]  = 1'b1;
            default: ;
          endcase
        end else begin
          e.nok[i] = 1'b1;
        end
      end
      e.sp[i] = m_sp[i];
    end
    e.en = m_en; e.mute = m_mute; e.boost = m_boost; e.aux = m_aux;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: compare one cycle after each driven item
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.tag, "ok",    AW'(a_ok),    AW'(e.ok));
      check(e.tag, "nok",   AW'(a_nok),   AW'(e.nok));
      check(e.tag, "trig",  AW'(a_trig),  AW'(e.trig));
      check(e.tag, "en",    AW'(a_en),    AW'(e.en));
      check(e.tag, "mute",  AW'(a_mute),  AW'(e.mute));
      check(e.tag, "boost", AW'(a_boost), AW'(e.boost));
      check(e.tag, "aux",   AW'(a_aux),   AW'(e.aux));
      for (int i = 0; i < 3; i++) check(e.tag, "setpt", a_sp[i], e.sp[i]);
    end
  end

  // watchdog
  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    cmd_token = '0;
    cmd_arg = '0;
    m_en = '0; m_mute = '0; m_boost = '0; m_aux = '0;
    for (int i = 0; i < 3; i++) m_sp[i] = '0;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state while held
    check("R1", "ok",   AW'(a_ok),   '0);
    check("R1", "nok",  AW'(a_nok),  '0);
    check("R1", "trig", AW'(a_trig), '0);
    check("R1", "bits", AW'({a_en, a_mute, a_boost, a_aux}), '0);
    for (int i = 0; i < 3; i++) check("R1", "setpt", a_sp[i], '0);
    @(negedge clk);
    rst_n = 1'b1;

    send(0, 8'h00, '0, "R1");                 // first cycle after release
    send(1, 8'h10, 16'h0001, "R3 R8");        // enable set
    send(1, 8'h11, 16'h0001, "R3 R10");       // mute: rejected by B
    send(1, 8'h12, 16'h0001, "R3 R9");        // boost: rejected by A
    send(1, 8'h40, 16'hFFFF, "R3 R9");        // aux: rejected by A
    send(1, 8'h30, 16'hA5C3, "R7 R10");       // set-point: rejected by B
    send(0, 8'h10, 16'h0000, "R2");           // valid low: ignored
    send(0, 8'h30, 16'h1234, "R2");
    send(1, 8'h20, 16'h0000, "R6");           // trigger
    send(1, 8'h20, 16'hFFFF, "R6");           // back-to-back trigger
    send(0, 8'h00, '0, "R6");                 // trigger must drop
    send(1, 8'h00, 16'hFFFF, "R4");           // undefined codes
    send(1, 8'hFF, 16'hFFFF, "R4");
    send(1, 8'h55, 16'h0000, "R4");
    send(1, 8'h13, 16'h0000, "R4");
    send(1, 8'h10, 16'hFFFE, "R3");           // only bit 0 counts
    send(1, 8'h11, 16'hFFFE, "R3 R10");
    send(1, 8'h12, 16'hFFFE, "R3 R9");
    send(1, 8'h40, 16'h0000, "R3 R9");
    send(1, 8'h30, 16'hFFFF, "R7");
    send(1, 8'h30, 16'h0000, "R7");
    send(1, 8'h30, 16'h8001, "R7");
    send(1, 8'h11, 16'h0001, "R5");           // alternating ok/nok
    send(1, 8'hFF, 16'h0001, "R5");
    send(1, 8'h12, 16'h0001, "R5");
    send(0, 8'h00, '0, "R2");
    send(0, 8'h00, '0, "R2");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule